// File: doc/BRIEF.md
# Two-Word EEPROM Command Mailbox

This block sits on a processor's register bus and lets software fetch 16-bit words from the small byte-wide identification memories of up to three daughter-card slots. Software first writes a slot select code to a select register, then writes a two-word read command to a data port. The second command word arms a one-shot read. The next read of the data port fetches two consecutive bytes from the chosen slot's memory and returns them as one big-endian word. That read also disarms the command.

The slot memories are reached through one shared, single-port, synchronous byte read interface, and each slot has its own "memory present" input. The two bytes are fetched in two back-to-back cycles. The bus read is held off with a ready signal until both bytes are available. Reads with no armed command, with no slot selected, or with the selected slot empty return all ones and finish at once. A read of the select register reports which slots hold a memory.

Top module: `eeprom_cmd_mailbox`

## Requirements
- R1: After reset no slot is selected, no command is armed and the command word position is the first word. A data-port read then returns 0xFFFF.
- R2: A write to the select register (address 0x12) stores the slot choice. 0x1700 selects slot 1 (memSlot=0), 0x1D00 selects slot 2 (memSlot=1), 0x3500 selects slot 3 (memSlot=2), and any other value selects no slot.
- R3: Writes to the data port (address 0x42) alternate between a first and a second command word. The second write arms the command and returns the position to the first word. The byte offset is bits 5:0 of the first word, so a read command is 0x180 plus the offset followed by 0x0000.
- R4: A data-port read while armed, with the selected slot present, returns the byte at the offset in bits 15:8 and the byte at offset+1 in bits 7:0, and it disarms the command. The memory address is 7 bits wide, so offset 63 reads bytes 63 and 64.
- R5: A data-port read while not armed returns 0xFFFF.
- R6: A data-port read while armed, with no slot selected or with the selected slot not present, returns 0xFFFF and disarms the command.
- R7: A read of the select register returns 0xFFFF with bit 0, 1 or 2 cleared when slotPresent bit 0, 1 or 2 (slot 1, 2 or 3) is high.
- R8: A bus transfer completes at the rising edge where busReq and busReady are both high. An armed data read that fetches from a present slot raises busReady in its third cycle. The memory is read at the offset in its first cycle and at offset+1 in its second cycle, and memRdEn is high only in those two cycles. Every other transfer is ready in its first cycle.
- R9: A read of any other address returns 0x0000. A write to any other address changes neither the slot choice nor the command state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Transfer request, held until busReady |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid while busReady |
| busReady | output | 1 | Transfer completes at this clock edge |
| slotPresent | input | 3 | Per-slot memory present flags |
| memRdEn | output | 1 | Byte read strobe to the slot memories |
| memSlot | output | 2 | Slot index of the byte read |
| memAddr | output | OFF_W+1 | Byte address of the read |
| memRdata | input | 8 | Byte returned one cycle after memRdEn |

## Verification
The bench targets offset 63, where a design that truncates offset+1 to six bits would return byte 0 in the low half. It tests select codes that differ from a valid one by a single bit, where loose decoding would pick a real slot, and armed reads from empty or unselected slots, which must still disarm so that a repeat read returns 0xFFFF. It also writes a third command word and then reads, which exposes a position counter that fails to wrap. It checks the exact latency of each transfer, so a design that captures a byte one cycle early or late returns the wrong byte order.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    RD_ZERO  = 2'd0,
    RD_ONES  = 2'd1,
    RD_PRES  = 2'd2,
    RD_FETCH = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic   selWr;    // store decoded slot choice
    logic   offWr;    // store offset from first command word
    logic   fetchLo;  // address offset+1 instead of offset
    logic   capHi;    // capture high byte from memory
    rdSrc_e rdSrc;    // read data source
  } mbxStrobe_t;

  typedef struct packed {
    logic       ok;
    logic [1:0] idx;
  } slotSel_t;

  function automatic slotSel_t decodeSel(input logic [15:0] code);
    slotSel_t s;
    s.ok  = 1'b1;
    s.idx = 2'd0;
    case (code)
      16'h1700: s.idx = 2'd0;
      16'h1D00: s.idx = 2'd1;
      16'h3500: s.idx = 2'd2;
      default:  s.ok  = 1'b0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SEL_ADDR  = 'h12,
  parameter int DATA_ADDR = 'h42
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              slotHit,
  output logic              busReady,
  output logic              memRdEn,
  output mbxStrobe_t        strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_DONE} state_e;

  state_e state, stateNxt;
  logic   cmdPos, cmdValid;
  logic   isSel, isData, fetchGo;

  assign isSel   = (busAddr == ADDR_W'(SEL_ADDR));
  assign isData  = (busAddr == ADDR_W'(DATA_ADDR));
  assign fetchGo = busReq && !busWrite && isData && cmdValid && slotHit;

  always_comb begin
    stateNxt     = state;
    busReady     = 1'b0;
    memRdEn      = 1'b0;
    strb         = '0;
    strb.rdSrc   = RD_ZERO;
    case (state)
      ST_IDLE: begin
        if (fetchGo) begin
          memRdEn  = 1'b1;
          stateNxt = ST_LO;
        end else if (busReq) begin
          busReady = 1'b1;
          if (busWrite) begin
            strb.selWr = isSel;
            strb.offWr = isData && !cmdPos;
          end else if (isData) begin
            strb.rdSrc = RD_ONES;
          end else if (isSel) begin
            strb.rdSrc = RD_PRES;
          end
        end
      end
      ST_LO: begin
        memRdEn      = 1'b1;
        strb.fetchLo = 1'b1;
        strb.capHi   = 1'b1;
        stateNxt     = ST_DONE;
      end
      default: begin
        busReady   = 1'b1;
        strb.rdSrc = RD_FETCH;
        stateNxt   = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cmdPos   <= 1'b0;
      cmdValid <= 1'b0;
    end else begin
      state <= stateNxt;
      if (busReq && busReady && isData) begin
        if (busWrite) begin
          cmdPos <= !cmdPos;
          if (cmdPos) cmdValid <= 1'b1;
        end else begin
          cmdValid <= 1'b0;
        end
      end
    end
  end

  p_ready_needs_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    busReady |-> busReq);
  p_mem_under_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (busReq && !busWrite && isData));
  p_read_disarms_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busReady && !busWrite && isData) |=> !cmdValid);
  p_second_word_arms_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busReady && busWrite && isData && cmdPos) |=> (cmdValid && !cmdPos));

endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int OFF_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  mbxStrobe_t       strb,
  input  logic [15:0]      busWdata,
  input  logic [2:0]       slotPresent,
  input  logic [7:0]       memRdata,
  output logic             slotHit,
  output logic [1:0]       memSlot,
  output logic [OFF_W:0]   memAddr,
  output logic [15:0]      busRdata
);

  localparam int MEM_AW = OFF_W + 1;

  slotSel_t         selReg;
  logic [OFF_W-1:0] offReg;
  logic [7:0]       hiByte;
  logic [3:0]       presPad;

  assign presPad = {1'b0, slotPresent};
  assign slotHit = selReg.ok && presPad[selReg.idx];
  assign memSlot = selReg.idx;
  assign memAddr = MEM_AW'(offReg) + MEM_AW'(strb.fetchLo);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg <= '0;
      offReg <= '0;
      hiByte <= '0;
    end else begin
      if (strb.selWr) selReg <= decodeSel(busWdata);
      if (strb.offWr) offReg <= busWdata[OFF_W-1:0];
      if (strb.capHi) hiByte <= memRdata;
    end
  end

  always_comb begin
    case (strb.rdSrc)
      RD_ONES:  busRdata = 16'hFFFF;
      RD_PRES:  busRdata = ~{13'd0, slotPresent};
      RD_FETCH: busRdata = {hiByte, memRdata};
      default:  busRdata = 16'h0000;
    endcase
  end

  p_lo_addr_follows_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.fetchLo |-> (memAddr == $past(memAddr) + MEM_AW'(1)));
  p_fetch_after_cap_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.capHi |=> (strb.rdSrc == RD_FETCH));

endmodule

// File: rtl/eeprom_cmd_mailbox.sv
module eeprom_cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int OFF_W     = 6,
  parameter int SEL_ADDR  = 'h12,
  parameter int DATA_ADDR = 'h42
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata,
  output logic              busReady,
  input  logic [2:0]        slotPresent,
  output logic              memRdEn,
  output logic [1:0]        memSlot,
  output logic [OFF_W:0]    memAddr,
  input  logic [7:0]        memRdata
);

  mbxStrobe_t strb;
  logic       slotHit;

  mbx_ctrl #(
    .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .slotHit(slotHit), .busReady(busReady),
    .memRdEn(memRdEn), .strb(strb)
  );

  mbx_datapath #(.OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .slotPresent(slotPresent), .memRdata(memRdata), .slotHit(slotHit),
    .memSlot(memSlot), .memAddr(memAddr), .busRdata(busRdata)
  );

endmodule

// File: tb/sim_eeprom_cmd_mailbox.sv
module sim_eeprom_cmd_mailbox;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_SEL = 8'h12, A_DATA = 8'h42, A_OTHER = 8'h14;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        busReq = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [15:0] busWdata = '0, busRdata;
  logic        busReady, memRdEn;
  logic [2:0]  slotPresent = 3'b000;
  logic [1:0]  memSlot;
  logic [6:0]  memAddr;
  logic [7:0]  memRdata = '0;

  int checks = 0, errors = 0;
  int mSel = -1, mOff = 0;
  bit mValid = 0, mPos = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_cmd_mailbox u0 (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busReady(busReady), .slotPresent(slotPresent), .memRdEn(memRdEn),
    .memSlot(memSlot), .memAddr(memAddr), .memRdata(memRdata)
  );

  function automatic logic [7:0] memByte(input int s, input int a);
    return 8'(s * 37 + a * 11 + 5);
  endfunction

  always @(posedge clk) if (memRdEn) memRdata <= memByte(int'(memSlot), int'(memAddr));

  function automatic int selOf(input logic [15:0] c);
    if (c == 16'h1700) return 0;
    if (c == 16'h1D00) return 1;
    if (c == 16'h3500) return 2;
    return -1;
  endfunction

  function automatic bit hitNow();
    return mValid && mSel >= 0 && slotPresent[mSel];
  endfunction

  function automatic logic [15:0] expData();
    if (!hitNow()) return 16'hFFFF;
    return {memByte(mSel, mOff), memByte(mSel, mOff + 1)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [7:0] a, input logic [15:0] d,
                      output logic [15:0] rd, output int lat);
    @(negedge clk);
    busReq = 1'b1; busWrite = wr; busAddr = a; busWdata = d;
    lat = 1;
    forever begin
      #1;
      if (busReady) break;
      @(negedge clk);
      lat++;
    end
    rd = busRdata;
    @(posedge clk);
    #1 busReq = 1'b0;
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [15:0] d, input string req);
    logic [15:0] rd; int lat;
    xfer(1'b1, a, d, rd, lat);
    check(lat == 1, req, lat, 1);
    if (a == A_SEL) mSel = selOf(d);
    else if (a == A_DATA) begin
      if (!mPos) mOff = int'(d[5:0]);
      else mValid = 1;
      mPos = !mPos;
    end
  endtask

  task automatic readData(input string req);
    logic [15:0] rd, e; int lat, el;
    e  = expData();
    el = hitNow() ? 3 : 1;
    xfer(1'b0, A_DATA, 16'h0, rd, lat);
    check(rd == e, req, rd, e);
    check(lat == el, {req, " latency R8"}, lat, el);
    mValid = 0;
  endtask

  task automatic readSel(input string req);
    logic [15:0] rd, e; int lat;
    e = 16'hFFFF & ~{13'd0, slotPresent};
    xfer(1'b0, A_SEL, 16'h0, rd, lat);
    check(rd == e && lat == 1, req, rd, e);
  endtask

  task automatic arm(input int off, input string req);
    doWrite(A_DATA, 16'h0180 + 16'(off), req);
    doWrite(A_DATA, 16'h0000, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd; int lat;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    check(busReady == 1'b0 && memRdEn == 1'b0, "R1 idle outputs", busReady, 0);
    readData("R1 read after reset");
    slotPresent = 3'b101;
    readSel("R7 presence 101");
    arm(5, "R3 arm");
    readData("R1 no slot after reset R6");

    // R2 / R4: each code, offsets 0 and 63
    slotPresent = 3'b111;
    doWrite(A_SEL, 16'h1700, "R2 code slot1");
    arm(0, "R3 arm off0");  readData("R4 slot1 off0");
    doWrite(A_SEL, 16'h1D00, "R2 code slot2");
    arm(63, "R3 arm off63"); readData("R4 slot2 off63 boundary");
    doWrite(A_SEL, 16'h3500, "R2 code slot3");
    arm(17, "R3 arm off17"); readData("R4 slot3 off17");
    readData("R5 second read after disarm");

    // R3: high bits of first word ignored, third word wraps
    doWrite(A_DATA, 16'hFFC9, "R3 first word");
    doWrite(A_DATA, 16'h0000, "R3 second word");
    doWrite(A_DATA, 16'h0182, "R3 third word");
    readData("R3 armed by earlier pair");
    doWrite(A_DATA, 16'h0000, "R3 fourth word");
    readData("R3 rearmed offset 2");

    // R2: near-miss codes select nothing; R6: absent slot disarms
    doWrite(A_SEL, 16'h1701, "R2 bad code");
    arm(4, "R3 arm");       readData("R6 no slot");
    doWrite(A_SEL, 16'h1D00, "R2 code slot2");
    slotPresent = 3'b101;
    arm(4, "R3 arm");       readData("R6 absent slot");
    readData("R6 disarmed after absent");

    // R9: other address
    slotPresent = 3'b111;
    doWrite(A_SEL, 16'h0000, "R2 clear select");
    doWrite(A_OTHER, 16'h1700, "R9 other write");
    doWrite(A_OTHER, 16'h0180, "R9 other write");
    arm(9, "R3 arm");
    readData("R9 select unchanged by other write");
    xfer(1'b0, A_OTHER, 16'h0, rd, lat);
    check(rd == 16'h0000 && lat == 1, "R9 other read", rd, 0);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      if ($urandom_range(0, 9) == 0) slotPresent = 3'($urandom);
      case (op)
        0, 1: begin
          int k = $urandom_range(0, 4);
          logic [15:0] c;
          c = (k == 0) ? 16'h1700 : (k == 1) ? 16'h1D00 : (k == 2) ? 16'h3500 : 16'($urandom);
          doWrite(A_SEL, c, "R2 random select");
        end
        2, 3, 4: doWrite(A_DATA, ($urandom_range(0, 1) == 1) ? 16'($urandom)
                                   : 16'h0180 + 16'($urandom_range(0, 63)), "R3 random word");
        5, 6, 7: readData("R4 random data read");
        8: readSel("R7 random presence");
        default: begin
          if ($urandom_range(0, 1) == 1) doWrite(A_OTHER, 16'($urandom), "R9 random other write");
          else begin
            xfer(1'b0, A_OTHER, 16'h0, rd, lat);
            check(rd == 16'h0000, "R9 random other read", rd, 0);
          end
        end
      endcase
    end

    // R1: reset mid-armed
    doWrite(A_SEL, 16'h1700, "R2 code slot1");
    arm(3, "R3 arm");
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    mSel = -1; mValid = 0; mPos = 0;
    readData("R1 reset disarms");
    doWrite(A_DATA, 16'h0000, "R3 word after reset");
    readData("R1 position reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule